// File: doc/BRIEF.md
# DMA Request Priority Arbiter

This block chooses which of several DMA request lines is served next and hands exactly one channel at a time to a transfer sequencer. It conditions the raw request pins by a programmable sense, removes masked channels, and picks a winner under either a fixed order or a rotating order. It then holds that grant until the sequencer reports that the service has finished. The bus cycles and the address and count logic sit in the sequencer, not here.

An 8-bit command register, loaded through a write strobe, sets the behaviour. Bit 2 switches the controller off. Bit 4 chooses rotating priority over fixed priority. Bit 6 makes the request pins active low. Bit 7 makes the acknowledge pins active high. Bits 0, 1, 3 and 5 are stored but have no effect on this block. The granted channel is given both as an acknowledge pin per channel and as a binary index with a valid flag.

Top module: `dma_req_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the command register to 0x00, clears the grant, and drives every acknowledge pin high (inactive under the reset sense). The rotation pointer restarts so that channel 0 is searched first.
- R2: With command bit 4 at 0 (fixed priority), the lowest-numbered channel that is requesting and unmasked wins. Channel 0 is highest and channel 3 lowest.
- R3: With command bit 4 at 1 (rotating priority), the search starts at the channel after the one whose service last completed and wraps past the last channel. The channel just serviced is therefore lowest.
- R4: Command bit 6 sets the request sense: 0 means a high pin requests, 1 means a low pin requests.
- R5: Command bit 7 sets the acknowledge sense: 0 means active low, 1 means active high. While a grant is held exactly one acknowledge pin, the one for `grant_idx`, is at the active level and all others are inactive. With no grant, all pins are inactive.
- R6: While command bit 2 is 1 no new grant is issued. A grant already held stays until its service ends.
- R7: A channel whose mask bit is 1 is never granted, whatever the level of its request pin.
- R8: Once given, a grant keeps the same index and stays valid until `svc_done` is sampled high. Request changes in the meantime have no effect on it.
- R9: A grant becomes visible the cycle after the clock edge at which an idle arbiter sees an eligible request. After `svc_done` is sampled with a grant held, `grant_valid` is low for the next cycle.
- R10: A command write takes effect at the clock edge where `cmd_wr` is high. The acknowledge sense follows the new value in that same cycle, and arbitration uses it from the next decision. Bits 0, 1, 3 and 5 leave grants and acknowledge levels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_wdata | input | 8 | Command value to load |
| dreq_pin | input | N_CH | Raw request pins, sense set by command bit 6 |
| chan_mask | input | N_CH | Per-channel mask, 1 blocks the channel |
| svc_done | input | 1 | Sequencer reports end of service for the held grant |
| dack_pin | output | N_CH | Registered acknowledge pins, sense set by command bit 7 |
| grant_valid | output | 1 | A channel is currently granted |
| grant_idx | output | $clog2(N_CH) | Index of the granted channel |

## Verification
The assertions assume that `svc_done` only matters while a grant is held, and that the mask and request inputs are stable around the sampling edge. The bench meets this by driving every input half a cycle away from the active edge. Random stimulus pulses `svc_done` freely, including when no grant is held, so that ignoring it there is exercised. Command writes are kept rare in random traffic so that long stretches run under one configuration. Directed cases cover every sense, priority and disable combination the requirements name.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CMD_W            = 8;
  localparam int CMD_OFF_BIT      = 2;
  localparam int CMD_ROTATE_BIT   = 4;
  localparam int CMD_REQ_LOW_BIT  = 6;
  localparam int CMD_ACK_HIGH_BIT = 7;

  typedef struct packed {
    logic ack_high;
    logic req_low;
    logic rotate;
    logic off;
  } arb_cfg_t;

  function automatic arb_cfg_t decode_cfg(input logic [CMD_W-1:0] c);
    arb_cfg_t r;
    r.ack_high = c[CMD_ACK_HIGH_BIT];
    r.req_low  = c[CMD_REQ_LOW_BIT];
    r.rotate   = c[CMD_ROTATE_BIT];
    r.off      = c[CMD_OFF_BIT];
    return r;
  endfunction
endpackage

// File: rtl/dma_arb_cmd_reg.sv
module dma_arb_cmd_reg
  import dma_arb_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmd_q,
  output arb_cfg_t     cfg_q,
  output arb_cfg_t     cfg_nxt
);
  logic [W-1:0] cmd_d;

  always_comb begin
    cmd_d = wr ? wdata : cmd_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cmd_q <= '0;
    else     cmd_q <= cmd_d;
  end

  assign cfg_q   = decode_cfg(cmd_q);
  assign cfg_nxt = rst ? decode_cfg('0) : decode_cfg(cmd_d);

  assert_cmd_load_R10: assert property (@(posedge clk) disable iff (rst)
    wr |=> cmd_q == $past(wdata));
  assert_cmd_keep_R10: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(cmd_q));
endmodule

// File: rtl/dma_arb_req_cond.sv
module dma_arb_req_cond #(
  parameter int N = 4
) (
  input  logic [N-1:0] dreq_pin,
  input  logic [N-1:0] mask,
  input  logic         req_low,
  output logic [N-1:0] eligible
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    assign eligible[i] = (dreq_pin[i] ^ req_low) & ~mask[i];
  end
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic          rotate,
  input  logic [IW-1:0] last,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] base;
  logic [IW:0]   cand;

  always_comb begin
    if (!rotate || last == IW'(N - 1)) base = '0;
    else                                base = last + 1'b1;
  end

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    cand = '0;
    for (int k = 0; k < N; k++) begin
      cand = {1'b0, base} + (IW+1)'(k);
      if (cand >= (IW+1)'(N)) cand = cand - (IW+1)'(N);
      if (!any && req[cand[IW-1:0]]) begin
        any = 1'b1;
        idx = cand[IW-1:0];
      end
    end
  end

  always_comb begin
    if (any) assert_pick_requesting_R2: assert (req[idx]);
    else     assert_pick_none_R7: assert (req == '0);
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic [N_CH-1:0]   dreq_pin,
  input  logic [N_CH-1:0]   chan_mask,
  input  logic              svc_done,
  output logic [N_CH-1:0]   dack_pin,
  output logic              grant_valid,
  output logic [IW-1:0]     grant_idx
);
  logic [CMD_W-1:0] cmd_q;
  arb_cfg_t         cfg_q, cfg_nxt;
  logic [N_CH-1:0]  eligible;
  logic             pick_any;
  logic [IW-1:0]    pick_idx;
  logic             gv_q, gv_nxt;
  logic [IW-1:0]    gi_q, gi_nxt;
  logic [IW-1:0]    last_q, last_nxt;
  logic [N_CH-1:0]  act_nxt;
  logic [N_CH-1:0]  dack_q;

  dma_arb_cmd_reg #(.W(CMD_W)) u_cmd (
    .clk(clk), .rst(rst), .wr(cmd_wr), .wdata(cmd_wdata),
    .cmd_q(cmd_q), .cfg_q(cfg_q), .cfg_nxt(cfg_nxt)
  );

  dma_arb_req_cond #(.N(N_CH)) u_cond (
    .dreq_pin(dreq_pin), .mask(chan_mask), .req_low(cfg_q.req_low),
    .eligible(eligible)
  );

  dma_arb_pick #(.N(N_CH)) u_pick (
    .req(eligible), .rotate(cfg_q.rotate), .last(last_q),
    .any(pick_any), .idx(pick_idx)
  );

  always_comb begin
    gv_nxt   = gv_q;
    gi_nxt   = gi_q;
    last_nxt = last_q;
    if (gv_q) begin
      if (svc_done) begin
        gv_nxt   = 1'b0;
        last_nxt = gi_q;
      end
    end else if (!cfg_q.off && pick_any) begin
      gv_nxt = 1'b1;
      gi_nxt = pick_idx;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_ack
    assign act_nxt[i] = gv_nxt && (gi_nxt == IW'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gv_q   <= 1'b0;
      gi_q   <= '0;
      last_q <= IW'(N_CH - 1);
      dack_q <= '1;
    end else begin
      gv_q   <= gv_nxt;
      gi_q   <= gi_nxt;
      last_q <= last_nxt;
      dack_q <= cfg_nxt.ack_high ? act_nxt : ~act_nxt;
    end
  end

  assign dack_pin    = dack_q;
  assign grant_valid = gv_q;
  assign grant_idx   = gi_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (gv_q && !svc_done) |=> (gv_q && $stable(gi_q)));
  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (gv_q && svc_done) |=> !gv_q);
  assert_ack_count_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(dack_q ^ {N_CH{~cfg_q.ack_high}}) == (gv_q ? 1 : 0));
  assert_no_grant_off_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(gv_q) |-> !$past(cfg_q.off));
  assert_no_masked_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(gv_q) |-> ((($past(chan_mask) >> gi_q) & N_CH'(1)) == '0));
endmodule

// File: tb/sim_dma_req_arbiter.sv
module sim_dma_req_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_wdata = '0;
  logic [N-1:0] dreq_pin = '0;
  logic [N-1:0] chan_mask = '0;
  logic svc_done = 1'b0;
  logic [N-1:0] dack_pin;
  logic grant_valid;
  logic [IW-1:0] grant_idx;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  string tag = "R1";

  // model state
  logic [7:0] m_cmd = '0;
  logic m_gv = 1'b0;
  logic [IW-1:0] m_gi = '0;
  logic [IW-1:0] m_last = IW'(N - 1);

  dma_req_arbiter #(.N_CH(N)) u0 (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .dreq_pin(dreq_pin), .chan_mask(chan_mask), .svc_done(svc_done),
    .dack_pin(dack_pin), .grant_valid(grant_valid), .grant_idx(grant_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [IW-1:0] pick(input logic [N-1:0] r, input logic rot,
                                         input logic [IW-1:0] last);
    int start = rot ? (int'(last) + 1) % N : 0;
    for (int k = 0; k < N; k++) begin
      int c = (start + k) % N;
      if (r[c]) return IW'(c);
    end
    return '0;
  endfunction

  function automatic logic [N-1:0] exp_dack();
    logic [N-1:0] a = '0;
    if (m_gv) a[m_gi] = 1'b1;
    return m_cmd[7] ? a : ~a;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] elig;
    if (rst) begin
      m_cmd = '0; m_gv = 1'b0; m_gi = '0; m_last = IW'(N - 1);
    end else begin
      elig = (dreq_pin ^ {N{m_cmd[6]}}) & ~chan_mask;
      if (m_gv) begin
        if (svc_done) begin m_gv = 1'b0; m_last = m_gi; end
      end else if (!m_cmd[2] && elig != '0) begin
        m_gv = 1'b1;
        m_gi = pick(elig, m_cmd[4], m_last);
      end
      if (cmd_wr) m_cmd = cmd_wdata;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected under 150000", cycles);
      finish_run();
    end
  end

  task automatic check_outputs();
    checks++;
    if (grant_valid !== m_gv) begin
      fails++;
      $display("FAIL %s grant_valid actual %0b expected %0b", tag, grant_valid, m_gv);
    end
    if (m_gv) begin
      checks++;
      if (grant_idx !== m_gi) begin
        fails++;
        $display("FAIL %s grant_idx actual %0d expected %0d", tag, grant_idx, m_gi);
      end
    end
    checks++;
    if (dack_pin !== exp_dack()) begin
      fails++;
      $display("FAIL %s dack_pin actual %b expected %b", tag, dack_pin, exp_dack());
    end
  endtask

  // one cycle: check outputs at falling edge, then drive the next inputs
  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] mk,
                      input logic dn, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    check_outputs();
    dreq_pin = rq; chan_mask = mk; svc_done = dn; cmd_wr = wr; cmd_wdata = wd;
  endtask

  task automatic wcmd(input logic [7:0] v);
    step('0, '0, 1'b1, 1'b1, v);
    step('0, '0, 1'b1, 1'b0, '0);
    step('0, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    // R1 reset state
    tag = "R1";
    repeat (3) step('0, '0, 1'b0, 1'b0, '0);
    @(negedge clk); rst = 1'b0;
    step('0, '0, 1'b0, 1'b0, '0);
    step('0, '0, 1'b0, 1'b0, '0);

    // R2 fixed priority
    tag = "R2";
    step(4'b1010, '0, 1'b0, 1'b0, '0);
    step(4'b1010, '0, 1'b0, 1'b0, '0);
    step(4'b1000, '0, 1'b1, 1'b0, '0);
    step(4'b1000, '0, 1'b0, 1'b0, '0);
    step(4'b0000, '0, 1'b0, 1'b0, '0);

    // R8 grant held while requests change
    tag = "R8";
    step(4'b0001, '0, 1'b0, 1'b0, '0);
    step(4'b0000, '0, 1'b0, 1'b0, '0);
    step(4'b1111, '0, 1'b0, 1'b0, '0);

    // R9 release then one idle cycle although requests remain
    tag = "R9";
    step(4'b1111, '0, 1'b1, 1'b0, '0);
    step(4'b1111, '0, 1'b0, 1'b0, '0);
    step(4'b1111, '0, 1'b0, 1'b0, '0);
    step(4'b0000, '0, 1'b1, 1'b0, '0);
    step(4'b0000, '0, 1'b0, 1'b0, '0);

    // R3 rotating priority with all requesting
    tag = "R3";
    wcmd(8'h10);
    for (int i = 0; i < 10; i++) begin
      step(4'b1111, '0, 1'b0, 1'b0, '0);
      step(4'b1111, '0, 1'b1, 1'b0, '0);
    end
    step(4'b0110, '0, 1'b0, 1'b0, '0);
    step(4'b0110, '0, 1'b1, 1'b0, '0);
    step('0, '0, 1'b0, 1'b0, '0);

    // R4 request pins active low
    tag = "R4";
    wcmd(8'h40);
    step(4'b1011, '0, 1'b0, 1'b0, '0);
    step(4'b1111, '0, 1'b1, 1'b0, '0);
    step(4'b1111, '0, 1'b0, 1'b0, '0);
    step(4'b1111, '0, 1'b0, 1'b0, '0);

    // R5 acknowledge active high
    tag = "R5";
    wcmd(8'h80);
    step(4'b0100, '0, 1'b0, 1'b0, '0);
    step(4'b0100, '0, 1'b0, 1'b0, '0);
    step(4'b0000, '0, 1'b1, 1'b0, '0);
    step(4'b0000, '0, 1'b0, 1'b0, '0);

    // R6 disabled: no new grant; held grant stays
    tag = "R6";
    step(4'b1000, '0, 1'b0, 1'b0, '0);
    step(4'b1000, '0, 1'b0, 1'b1, 8'h04);
    step(4'b1111, '0, 1'b0, 1'b0, '0);
    step(4'b1111, '0, 1'b1, 1'b0, '0);
    step(4'b1111, '0, 1'b0, 1'b0, '0);
    step(4'b1111, '0, 1'b0, 1'b0, '0);
    wcmd(8'h00);

    // R7 masking
    tag = "R7";
    step(4'b1111, 4'b0111, 1'b0, 1'b0, '0);
    step(4'b1111, 4'b0111, 1'b1, 1'b0, '0);
    step(4'b1111, 4'b1111, 1'b0, 1'b0, '0);
    step(4'b1111, 4'b1111, 1'b0, 1'b0, '0);
    step(4'b0000, 4'b0000, 1'b0, 1'b0, '0);

    // R10 unused command bits have no effect
    tag = "R10";
    wcmd(8'h2B);
    step(4'b0110, '0, 1'b0, 1'b0, '0);
    step(4'b0110, '0, 1'b0, 1'b0, '0);
    step(4'b0000, '0, 1'b1, 1'b0, '0);
    step(4'b0000, '0, 1'b0, 1'b0, '0);

    // random traffic with rare command writes
    tag = "R8";
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      logic wr = ($urandom % 16) == 0;
      step(N'($urandom), N'($urandom % 4 == 0 ? $urandom : 0),
           ($urandom % 3) == 0, wr, 8'($urandom));
    end
    step('0, '0, 1'b0, 1'b0, '0);
    finish_run();
  end
endmodule